// File: doc/BRIEF.md
# MII nibble transmit framer

This block sits between a MAC's frame source and a 10/100 PHY. The frame source hands it bytes one at a time over a valid/ready/last handshake. The block turns them into the 4-bit media-independent transmit stream: TXD, TX_EN and TX_ER, all clocked by the transmit clock that the PHY supplies. Every frame opens with fifteen 0x5 nibbles and one 0xD nibble, which together form the preamble and the start-of-frame delimiter. The bytes follow, each split low nibble first. The source must already have appended the frame check sequence, because the block passes the address, type/length, payload and check bytes through one path without looking at them.

Three error paths support PHY-side checking. A per-byte error request raises TX_ER on both nibbles of that byte. If the source fails to supply a byte in the middle of a frame, the block emits one errored byte position and then closes the frame. A test request, sampled at frame start, adds one stray nibble after the final byte so the frame ends off a byte boundary. Between frames the block holds TX_EN low for a full inter-frame gap.

Top module: `mii_tx_framer`

## Requirements
- R1: While rst_n is low at a clock edge, the next cycle shows tx_en=0, tx_er=0, txd=0 and in_ready=0.
- R2: When in_valid is high at an edge and the block is idle, tx_en rises in the next cycle. The first 15 nibbles of the frame (positions 0 to 14) are 0x5 with tx_er low.
- R3: Nibble position 15 is 0xD, and in_ready is high during that cycle.
- R4: Each accepted byte goes out over two consecutive cycles: bits [3:0] at an even position, then bits [7:4] at the following odd position.
- R5: in_ready is high only during the 0xD cycle and during the high-nibble cycle of a byte that was not flagged in_last. A byte is taken at an edge where both in_valid and in_ready are high, so one byte is taken every two clocks at most.
- R6: Without a dribble request, tx_en falls in the cycle right after the high nibble of the byte taken with in_last=1, so the frame ends byte-aligned.
- R7: force_err is sampled together with its byte. When it is set, tx_er is high on both nibbles of that byte and on no others.
- R8: If in_valid is low at an edge where in_ready is high, the next two cycles carry txd=0x0 with tx_en and tx_er both high. The frame then ends. No dribble nibble is added, even if one was requested.
- R9: dribble_req is sampled at the edge that starts a frame. When it is set, one extra nibble 0x0 with tx_er low follows the final high nibble. tx_en then falls after that even-position nibble.
- R10: tx_en stays low for at least 24 cycles between frames. A request held during the gap starts the next frame right after the 24th low cycle.
- R11: Whenever tx_en is low, txd is 0 and tx_er is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock from the PHY |
| rst_n | input | 1 | Synchronous reset, active low |
| in_data | input | 8 | Frame byte from the source |
| in_valid | input | 1 | in_data holds a byte; when idle, also asks for a new frame |
| in_last | input | 1 | The offered byte is the final byte of the frame |
| in_ready | output | 1 | The block takes the offered byte at the next edge |
| force_err | input | 1 | Mark the offered byte as errored on the wire |
| dribble_req | input | 1 | Test request: append one stray nibble to the frame being started |
| txd | output | 4 | Transmit nibble |
| tx_en | output | 1 | Transmit enable |
| tx_er | output | 1 | Transmit error |

## Verification
Three functions can meet in the same frame end. A forced error on the final byte can be followed at once by a requested dribble nibble. A source that goes quiet can also underrun while a dribble request is armed. The bench provokes both cases. In the first, it checks that tx_er drops exactly on the dribble nibble. In the second, it checks that the underrun's two errored nibbles close the frame and no dribble nibble appears. Each case is judged cycle by cycle against a queue of expected nibbles that the bench builds from the frame description. The bench also sends a frame back-to-back with a held request and checks that the gap is exactly 24 cycles long.

// File: rtl/mii_tx_pkg.sv
// Shared definitions for the MII transmit framer.
// Assumes a 4-bit nibble path and an 8-bit host byte.
package mii_tx_pkg;
    localparam int NIB_W  = 4;
    localparam int BYTE_W = 2 * NIB_W;

    localparam logic [NIB_W-1:0] NIB_PREAMBLE = 4'h5;
    localparam logic [NIB_W-1:0] NIB_DELIM    = 4'hD;
    localparam logic [NIB_W-1:0] NIB_FILL     = 4'h0;

    // Each state names the nibble that is on the wire while the block is in it.
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PRE,
        ST_SFD,
        ST_LO,
        ST_HI,
        ST_DRB,
        ST_UNL,
        ST_UNH,
        ST_GAP
    } tx_state_t;
endpackage

// File: rtl/mii_tx_seq.sv
// Nibble sequencer: steps through preamble, delimiter, data byte halves,
// optional dribble or underrun tail, then the inter-frame gap.
// Assumes: nxt_state is registered in the same edge by the datapath, so the
// state here always names the nibble currently on the wire.
module mii_tx_seq
    import mii_tx_pkg::*;
#(
    parameter int PRE_NIBBLES = 15,
    parameter int IFG_NIBBLES = 24
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      in_valid,
    input  logic      in_last,
    input  logic      dribble_req,
    output tx_state_t nxt_state,
    output logic      take,
    output logic      in_ready
);
    localparam int PW = $clog2(PRE_NIBBLES + 1);
    localparam int GW = $clog2(IFG_NIBBLES + 1);
    localparam logic [PW-1:0] PRE_LAST  = PW'(PRE_NIBBLES - 1);
    localparam logic [GW-1:0] GAP_FIRST = GW'(IFG_NIBBLES - 1);

    tx_state_t       state;
    logic [PW-1:0]   pre_cnt;
    logic [GW-1:0]   gap_cnt;
    logic            last_seen;
    logic            drib_arm;
    logic            starting;

    // Ready while the delimiter or the high nibble of a non-final byte is out.
    always_comb begin
        in_ready = (state == ST_SFD) || ((state == ST_HI) && !last_seen);
        take     = in_ready && in_valid;
    end

    // Next-state decision for the nibble sequence.
    always_comb begin
        nxt_state = state;
        unique case (state)
            ST_IDLE: if (in_valid) nxt_state = ST_PRE;
            ST_PRE:  if (pre_cnt == PRE_LAST) nxt_state = ST_SFD;
            ST_SFD, ST_HI: begin
                if ((state == ST_HI) && last_seen)
                    nxt_state = drib_arm ? ST_DRB : ST_GAP;
                else if (in_valid)
                    nxt_state = ST_LO;
                else
                    nxt_state = ST_UNL;
            end
            ST_LO:   nxt_state = ST_HI;
            ST_DRB:  nxt_state = ST_GAP;
            ST_UNL:  nxt_state = ST_UNH;
            ST_UNH:  nxt_state = ST_GAP;
            ST_GAP: begin
                if (gap_cnt == '0)
                    nxt_state = in_valid ? ST_PRE : ST_IDLE;
            end
            default: nxt_state = ST_IDLE;
        endcase
        starting = (nxt_state == ST_PRE) && (state != ST_PRE);
    end

    // State register and the preamble / gap counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            pre_cnt <= '0;
            gap_cnt <= '0;
        end else begin
            state <= nxt_state;
            if (starting)
                pre_cnt <= '0;
            else if (state == ST_PRE)
                pre_cnt <= pre_cnt + 1'b1;
            if ((nxt_state == ST_GAP) && (state != ST_GAP))
                gap_cnt <= GAP_FIRST;
            else if ((state == ST_GAP) && (gap_cnt != '0))
                gap_cnt <= gap_cnt - 1'b1;
        end
    end

    // Per-frame flags: final byte seen, dribble request latched at start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_seen <= 1'b0;
            drib_arm  <= 1'b0;
        end else if (starting) begin
            last_seen <= 1'b0;
            drib_arm  <= dribble_req;
        end else if (take) begin
            last_seen <= in_last;
        end
    end

    // The preamble counter never runs past its final position (R2).
    assert_pre_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PRE) |-> (pre_cnt <= PRE_LAST));

    // After the final byte's high nibble no further byte is asked for (R5).
    assert_no_ready_after_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HI && last_seen) |=> !in_ready);
endmodule

// File: rtl/mii_tx_nib.sv
// Output datapath: registers txd, tx_en and tx_er from the sequencer's next
// state. Holds the high nibble and error flag of the byte being sent.
// Assumes: ST_LO is entered only on an edge where a byte is taken.
module mii_tx_nib
    import mii_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  tx_state_t         nxt_state,
    input  logic              take,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              force_err,
    output logic [NIB_W-1:0]  txd,
    output logic              tx_en,
    output logic              tx_er
);
    logic [NIB_W-1:0] hold_hi;
    logic             hold_err;
    logic [NIB_W-1:0] d_n;
    logic             en_n;
    logic             er_n;

    // Pick the nibble and flags that belong to the coming state.
    always_comb begin
        d_n  = NIB_FILL;
        en_n = 1'b1;
        er_n = 1'b0;
        unique case (nxt_state)
            ST_PRE:         d_n = NIB_PREAMBLE;
            ST_SFD:         d_n = NIB_DELIM;
            ST_LO: begin
                d_n  = in_data[NIB_W-1:0];
                er_n = force_err;
            end
            ST_HI: begin
                d_n  = hold_hi;
                er_n = hold_err;
            end
            ST_DRB:         d_n = NIB_FILL;
            ST_UNL, ST_UNH: er_n = 1'b1;
            default:        en_n = 1'b0;
        endcase
    end

    // Output registers toward the PHY.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            txd   <= '0;
            tx_en <= 1'b0;
            tx_er <= 1'b0;
        end else begin
            txd   <= d_n;
            tx_en <= en_n;
            tx_er <= er_n;
        end
    end

    // Keep the upper half and error mark of an accepted byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_hi  <= '0;
            hold_err <= 1'b0;
        end else if (take) begin
            hold_hi  <= in_data[BYTE_W-1:NIB_W];
            hold_err <= force_err;
        end
    end

    // The wire is quiet whenever transmit enable is low (R11).
    assert_quiet_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |-> (!tx_er && txd == '0));
endmodule

// File: rtl/mii_tx_framer.sv
// Top of the MII nibble transmit framer: host byte handshake in, 4-bit
// transmit stream out, all on the PHY transmit clock.
// Assumes the host supplies complete frames, check sequence included.
module mii_tx_framer
    import mii_tx_pkg::*;
#(
    parameter int PRE_NIBBLES = 15,
    parameter int IFG_NIBBLES = 24
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] in_data,
    input  logic       in_valid,
    input  logic       in_last,
    output logic       in_ready,
    input  logic       force_err,
    input  logic       dribble_req,
    output logic [3:0] txd,
    output logic       tx_en,
    output logic       tx_er
);
    localparam int GW = $clog2(IFG_NIBBLES + 1);
    localparam logic [GW-1:0] GAP_FULL = GW'(IFG_NIBBLES);

    tx_state_t nxt_state;
    logic      take;

    mii_tx_seq #(
        .PRE_NIBBLES(PRE_NIBBLES),
        .IFG_NIBBLES(IFG_NIBBLES)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_last    (in_last),
        .dribble_req(dribble_req),
        .nxt_state  (nxt_state),
        .take       (take),
        .in_ready   (in_ready)
    );

    mii_tx_nib u_nib (
        .clk      (clk),
        .rst_n    (rst_n),
        .nxt_state(nxt_state),
        .take     (take),
        .in_data  (in_data),
        .force_err(force_err),
        .txd      (txd),
        .tx_en    (tx_en),
        .tx_er    (tx_er)
    );

    // Saturating count of low transmit-enable cycles, used to check the gap.
    logic [GW-1:0] low_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n)
            low_cnt <= GAP_FULL;
        else if (tx_en)
            low_cnt <= '0;
        else if (low_cnt < GAP_FULL)
            low_cnt <= low_cnt + 1'b1;
    end

    // A frame opens with a preamble nibble (R2).
    assert_first_nibble_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_en) |-> (txd == 4'h5 && !tx_er));

    // A taken byte's low half is on the wire in the next cycle (R4).
    assert_low_half_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && in_valid) |=> (tx_en && txd == $past(in_data[3:0])));

    // A missing byte turns into an errored nibble (R8).
    assert_underrun_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && !in_valid) |=> (tx_en && tx_er && txd == 4'h0));

    // Ready is only offered in the middle of a frame (R5).
    assert_ready_in_frame_R5: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> tx_en);

    // No frame starts before the full gap has elapsed (R10).
    assert_gap_len_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_en) |-> (low_cnt == GAP_FULL));
endmodule

// File: tb/mii_tx_framer_tb.sv
`timescale 1ns/1ps
// Bench: behavioural model builds the expected nibble stream of each frame
// in a queue; every clock the outputs are compared against its head.
module mii_tx_framer_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] in_data = '0;
    logic       in_valid = 1'b0;
    logic       in_last = 1'b0;
    logic       in_ready;
    logic       force_err = 1'b0;
    logic       dribble_req = 1'b0;
    logic [3:0] txd;
    logic       tx_en;
    logic       tx_er;

    always #10 clk = ~clk;

    mii_tx_framer u_dut (
        .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
        .in_last(in_last), .in_ready(in_ready), .force_err(force_err),
        .dribble_req(dribble_req), .txd(txd), .tx_en(tx_en), .tx_er(tx_er)
    );

    typedef struct {
        logic       en;
        logic       er;
        logic [3:0] d;
        logic       rdy;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    int    vectors = 0;
    int    fails = 0;

    // host driver state
    logic [7:0] fbytes[$];
    logic       ferr[$];
    int         nbytes = 0;
    int         kidx = 0;
    int         und_at = -1;
    logic       rdy_snap = 1'b0;

    function automatic void push(logic en, logic er, logic [3:0] d, logic rdy, string tag);
        exp_t e;
        e.en = en; e.er = er; e.d = d; e.rdy = rdy;
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endfunction

    task automatic compare(exp_t e, string tag);
        vectors++;
        if (tx_en !== e.en || tx_er !== e.er || txd !== e.d || in_ready !== e.rdy) begin
            fails++;
            $display("FAIL %s: got en=%b er=%b txd=%h rdy=%b, expected en=%b er=%b txd=%h rdy=%b",
                     tag, tx_en, tx_er, txd, in_ready, e.en, e.er, e.d, e.rdy);
        end
    endtask

    // One clock: compare at the falling edge, then update the host inputs.
    task automatic tick();
        exp_t  e;
        string t;
        logic  acc;
        @(negedge clk);
        if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
        end else begin
            e.en = 1'b0; e.er = 1'b0; e.d = 4'h0; e.rdy = 1'b0;
            t = "R11";
        end
        compare(e, t);
        acc = in_valid && rdy_snap;
        if (acc) kidx++;
        dribble_req = 1'b0;
        if (kidx < nbytes && kidx != und_at) begin
            in_valid  = 1'b1;
            in_data   = fbytes[kidx];
            in_last   = (kidx == nbytes - 1);
            force_err = ferr[kidx];
        end else begin
            in_valid  = 1'b0;
            in_data   = 8'h00;
            in_last   = 1'b0;
            force_err = 1'b0;
        end
        rdy_snap = in_ready;
    endtask

    // Build the expected stream of one frame, start it, and run it to the end of its gap.
    task automatic run_frame(int nb, int und, bit drib, logic [7:0] seed, logic [31:0] emask);
        int nsent;
        fbytes.delete();
        ferr.delete();
        for (int i = 0; i < nb; i++) begin
            fbytes.push_back(seed + 8'(i * 37));
            ferr.push_back(emask[i]);
        end
        for (int p = 0; p < 15; p++) push(1'b1, 1'b0, 4'h5, 1'b0, "R2");
        push(1'b1, 1'b0, 4'hD, 1'b1, "R3");
        nsent = (und >= 0) ? und : nb;
        for (int i = 0; i < nsent; i++) begin
            push(1'b1, ferr[i], fbytes[i][3:0], 1'b0, ferr[i] ? "R7" : "R4");
            push(1'b1, ferr[i], fbytes[i][7:4], (i != nb - 1), ferr[i] ? "R7" : "R5");
        end
        if (und >= 0) begin
            push(1'b1, 1'b1, 4'h0, 1'b0, "R8");
            push(1'b1, 1'b1, 4'h0, 1'b0, "R8");
            push(1'b0, 1'b0, 4'h0, 1'b0, "R8");
        end else if (drib) begin
            push(1'b1, 1'b0, 4'h0, 1'b0, "R9");
            push(1'b0, 1'b0, 4'h0, 1'b0, "R9");
        end else begin
            push(1'b0, 1'b0, 4'h0, 1'b0, "R6");
        end
        for (int g = 1; g < 24; g++) push(1'b0, 1'b0, 4'h0, 1'b0, "R10");
        nbytes = nb; kidx = 0; und_at = und; rdy_snap = 1'b0;
        in_valid = 1'b1; in_data = fbytes[0]; in_last = (nb == 1);
        force_err = ferr[0]; dribble_req = drib;
        while (exp_q.size() > 0) tick();
    endtask

    initial begin
        #(20.0 * 200000);
        fails++;
        $display("FAIL watchdog: got no end of run, expected end before cycle limit");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        exp_t z;
        z.en = 1'b0; z.er = 1'b0; z.d = 4'h0; z.rdy = 1'b0;
        repeat (3) @(negedge clk);
        compare(z, "R1");
        rst_n = 1'b1;
        repeat (5) tick();
        run_frame(4, -1, 1'b0, 8'h3C, 32'h0);            // plain frame
        run_frame(1, -1, 1'b0, 8'hA7, 32'h1);            // back-to-back, errored byte
        run_frame(3, -1, 1'b1, 8'h51, 32'h4);            // error on final byte, then dribble
        run_frame(5, 2, 1'b1, 8'hE2, 32'h0);             // underrun with dribble armed
        repeat (4) tick();
        run_frame(3, 0, 1'b0, 8'h10, 32'h0);             // underrun at first byte
        repeat (10) tick();
        run_frame(6, -1, 1'b0, 8'hF0, 32'h0A);           // scattered errors
        repeat (3) tick();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule